// File: doc/BRIEF.md
# Program/Erase Status Read Responder

This block answers reads on the device side of a nonvolatile memory while an internally timed program or erase operation runs. A one-cycle start pulse, together with the operation kind and the byte being written, begins a countdown whose length in clock cycles comes from a parameter for each operation kind. During that window the block drives `busy` high. It also substitutes a status byte for the array data on every read response.

The status byte carries two indications at once. Bit 7 is a polling bit. For a program it is the inverse of bit 7 of the byte being written. For an erase it is 0, the inverse of the erased value. Bit 6 is a toggle bit that flips on every accepted read. Bits 5 to 0 read 0. Once the countdown ends, reads return the array byte that the surrounding logic presents on `arr_rdata` in the cycle the read is accepted. A new access may follow as soon as `busy` has dropped.

Reads use a valid/ready request channel and a valid/ready response channel with one response register. A read is accepted on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that is not taken stays unchanged until `rsp_ready` is high. Command decoding and addressing are handled outside this block.

Top module: `pe_status_responder`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are 0, `rd_ready` is 1, and the toggle bit holds 0.
- R2: A start accepted while idle with `op_erase`=0 raises `busy` after that clock edge and keeps it high for exactly PROG_CYCLES cycles.
- R3: A start accepted while idle with `op_erase`=1 keeps `busy` high for exactly ERASE_CYCLES cycles.
- R4: A start pulse that arrives while `busy` is high has no effect: the duration, the operation kind and the latched byte are all unchanged.
- R5: A read accepted while a program is running returns, in bit 7, the inverse of bit 7 of the byte latched at start.
- R6: A read accepted while an erase is running returns 0 in bit 7.
- R7: Each read accepted while busy returns, in bit 6, the inverse of the previous toggle value and stores that new value. Idle cycles, stalled requests and reads accepted while not busy leave the toggle unchanged. The first status read after reset returns 1 in bit 6.
- R8: A read accepted while busy returns 0 in bits 5 to 0.
- R9: A read accepted while not busy returns the value of `arr_rdata` in its acceptance cycle. This includes the cycle in which a start pulse is accepted.
- R10: `rd_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| op_erase | input | 1 | Operation kind with start: 0 program, 1 erase |
| load_byte | input | 8 | Byte being programmed, sampled with start |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| arr_rdata | input | 8 | Array byte for the current read address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte (array data or status) |
| busy | output | 1 | Internal operation in progress |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that `arr_rdata` is settled for the address of the request in the cycle that request is accepted, and that both duration parameters are at least 1. The stimulus meets these conditions. It drives every input on the falling edge and presents a freshly computed array byte for each read. It uses short duration parameters, so every byte value can be programmed once under a read pattern that changes from byte to byte. It also raises starts during busy windows and holds `rsp_ready` low for several cycles while requests are pending.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  localparam int unsigned DW       = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  function automatic logic [DW-1:0] status_byte(input logic poll, input logic tog);
    logic [DW-1:0] s;
    s = '0;
    s[POLL_BIT] = poll;
    s[TOG_BIT]  = tog;
    return s;
  endfunction
endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer
  import pe_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 50,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e op_in,
  input  logic     load_msb,
  output logic     busy,
  output logic     poll_bit
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  op_kind_e      op_q;
  logic          ld7_q;

  assign last     = (op_q == OP_ERASE) ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
  assign poll_bit = (op_q == OP_ERASE) ? 1'b0 : ~ld7_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      op_q  <= OP_PROG;
      ld7_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        op_q  <= op_in;
        ld7_q <= load_msb;
      end
    end else if (cnt == last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == last) |=> !busy);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= last));

  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(ld7_q)));

  p_erase_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op_in == OP_ERASE) |=> !poll_bit);
endmodule

// File: rtl/pe_read_resp.sv
module pe_read_resp
  import pe_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [DW-1:0] arr_rdata,
  input  logic          busy,
  input  logic          poll_bit,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  logic tog;
  logic fire;

  assign rd_ready = !rsp_valid || rsp_ready;
  assign fire     = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      tog       <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      if (busy) begin
        rsp_data <= status_byte(poll_bit, ~tog);
        tog      <= ~tog;
      end else begin
        rsp_data <= arr_rdata;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_tog_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && busy) |=> $stable(tog));

  p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy) |=> (rsp_data[5:0] == '0));

  p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> (rsp_data == $past(arr_rdata)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/pe_status_responder.sv
module pe_status_responder
  import pe_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 50,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_erase,
  input  logic [7:0] load_byte,
  input  logic       rd_valid,
  output logic       rd_ready,
  input  logic [7:0] arr_rdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       busy
);
  logic poll_bit;

  pe_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_in   (op_kind_e'(op_erase)),
    .load_msb(load_byte[POLL_BIT]),
    .busy    (busy),
    .poll_bit(poll_bit)
  );

  pe_read_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .arr_rdata(arr_rdata),
    .busy     (busy),
    .poll_bit (poll_bit),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );

  p_ready_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready == (!rsp_valid || rsp_ready));

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !rsp_valid));
endmodule

// File: tb/sim_pe_status_responder.sv
module sim_pe_status_responder;
  localparam int CLK_PERIOD = 10;
  localparam int P = 12;
  localparam int E = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [7:0] load_byte = '0, arr_rdata = '0;
  logic rd_ready, rsp_valid, busy;
  logic [7:0] rsp_data;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic m_busy = 0, m_tog = 0, m_b7 = 0, m_er = 0, m_rv = 0;
  logic [7:0] m_rdata = '0;
  int m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_status_responder #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .load_byte(load_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .arr_rdata(arr_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // one clock cycle with a model update computed from the requirements
  task automatic cyc(input logic s, input logic e, input logic [7:0] d,
                     input logic r, input logic rdy, input logic [7:0] a);
    logic exp_rr, fire;
    string tagd;
    @(negedge clk);
    start = s; op_erase = e; load_byte = d; rd_valid = r; rsp_ready = rdy; arr_rdata = a;
    #1;
    exp_rr = !m_rv || rdy;
    chk(rd_ready == exp_rr, "R10 rd_ready", rd_ready, exp_rr);
    fire = r && exp_rr;
    tagd = "R10 hold";
    @(posedge clk);
    if (fire) begin
      m_rv = 1;
      if (m_busy) begin
        m_rdata = {(m_er ? 1'b0 : ~m_b7), ~m_tog, 6'b0};
        m_tog = ~m_tog;
        tagd = m_er ? "R6 R7 R8" : "R5 R7 R8";
      end else begin
        m_rdata = a;
        tagd = "R9";
      end
    end else if (rdy) m_rv = 0;
    if (m_busy) begin
      m_left--;
      if (m_left == 0) m_busy = 0;
    end else if (s) begin
      m_busy = 1; m_left = e ? E : P; m_b7 = d[7]; m_er = e;
    end
    #1;
    chk(busy == m_busy, "R2 R3 R4 busy", busy, m_busy);
    chk(rsp_valid == m_rv, "R10 rsp_valid", rsp_valid, m_rv);
    if (m_rv) chk(rsp_data == m_rdata, tagd, rsp_data, m_rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int bc;
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(rd_ready == 1, "R1 rd_ready", rd_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R1: first status read after reset shows toggle bit 1 (model starts at 0)
    // program sweep over every byte value, read density varies per byte
    for (int b = 0; b < 256; b++) begin
      cyc(1'b1, 1'b0, 8'(b), 1'(b % 2), 1'b1, 8'(b) ^ 8'h5A);
      bc = busy ? 1 : 0;
      for (int k = 0; k < 1000 && busy; k++) begin
        // R4: a start during busy (erase, other byte) must be ignored
        cyc((k == 2), 1'b1, ~8'(b), ((k % ((b % 3) + 1)) == 0), 1'b1, 8'(b + k));
        if (busy) bc++;
      end
      chk(bc == P, "R2 R4 program length", bc, P);
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'(b * 7 + 3));
      cyc(1'b0, 1'b0, 8'h00, 1'(b % 2), 1'b1, 8'(b * 13 + 1));
    end

    // erase sweep with a program start raised while busy
    for (int j = 0; j < 8; j++) begin
      cyc(1'b1, 1'b1, 8'(j * 33), 1'b1, 1'b1, 8'(j));
      bc = busy ? 1 : 0;
      for (int k = 0; k < 1000 && busy; k++) begin
        cyc((k == j), 1'b0, 8'h00, ((k % (j + 1)) == 0), 1'b1, 8'(k));
        if (busy) bc++;
      end
      chk(bc == E, "R3 R4 erase length", bc, E);
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'(j + 100));
    end

    // back-pressure during a program: stalled requests must not toggle bit 6
    cyc(1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h11);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'(k));
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h22);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h33);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
    for (int k = 0; k < P + 2; k++) cyc(1'b0, 1'b0, 8'h00, 1'(k % 2), 1'(k % 3 != 0), 8'(k + 200));
    // stall while idle: array data held
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hC3);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h3C);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00);

    finished = 1;
    summary();
  end
endmodule